// File: doc/BRIEF.md
# Burst Target Prefetch Channel

This block is one high-throughput channel of a synchronous external-bus target. An outside initiator reads and writes an internal memory window through it, one 32-bit word per request. The channel keeps two 32-byte read lines that work in alternation. When a read is served from one line, the other line is loaded from internal memory with the next sequential line, so a streaming initiator rarely waits on memory. Writes gather in a single 32-byte write line and are pushed to memory as a group.

Two inputs set the channel's window: an inclusive lowest and highest byte address. Requests outside the window are not claimed, so a neighbouring channel or the control channel can take them. A DMA request output tells an external initiator when a long burst can proceed. It rises while a loaded read line or an empty write line is on hand, and it falls after an acknowledge once neither is on hand. Four copies of this block can sit beside a general-purpose control channel, each with its own window.

The controller is a five-state machine. IDLE accepts a claimed request. It goes to RESP after serving a read hit or storing a write. It goes to DRAIN when a write targets a different line from the pending write data, or when a read overlaps that data. It goes to FETCH on a read miss. RESP returns to IDLE, or goes to DRAIN when the write line is full or the write just stored was marked last. DRAIN returns to IDLE once every pending word has been written. FETCH waits for the line loader to go quiet, discards both read lines, starts a load of the requested line into line 0, and moves to LOAD. LOAD returns to IDLE when the last word arrives, and the held request is then served as a hit.

Top module: `burst_prefetch_chan`

## Requirements
- R1: `ext_claim` is high exactly when `ext_req` is high and `win_lo <= ext_addr <= win_hi` (both bounds inclusive). A request that is not claimed never gets `ext_ack` and causes no memory traffic.
- R2: A read that finds neither read line loaded with its 32-byte line fetches that line from memory as eight 4-byte word reads. It then answers with `ext_ack` and the addressed word on `ext_rdata`.
- R3: A read served from one read line starts a load of the next 32-byte line into the other line, unless the other line already holds or is loading that line, or that line starts above `win_hi`. Reads of a line already loaded cause no memory reads.
- R4: A read miss discards both read lines, so a line that was loaded before the miss must be fetched again on its next read.
- R5: Writes to the same 32-byte line are held in the write line (one word per 4-byte slot, a later write to a slot replaces it) and cause no memory write while none of the flush conditions applies.
- R6: When all eight slots of the write line hold data, the channel writes all eight words to memory.
- R7: A write with `ext_last` high is acknowledged and then makes the channel write every held word to memory.
- R8: A write to a different line from the held write data first writes the held words to memory, then stores the new word.
- R9: A read of a line with held write data first writes that data to memory, then returns the new value, never a stale copy from a read line.
- R10: `dma_req` is 0 in reset. It is 1 in the cycle after a cycle in which a read line is loaded or the write line is empty. Otherwise it keeps its value until `dma_ack`, after which it is 0.
- R11: `ext_ack` is a one-cycle pulse per accepted request, and `ext_rdata` is valid with it for reads. The initiator holds the request until it sees `ext_ack`.
- R12: While `rst_n` is low, `ext_ack`, `mem_req` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_lo | input | AW | Lowest byte address of the channel window |
| win_hi | input | AW | Highest byte address of the channel window (inclusive) |
| ext_req | input | 1 | Initiator request, held until acknowledged |
| ext_we | input | 1 | 1 = write, 0 = read |
| ext_addr | input | AW | Word-aligned byte address |
| ext_wdata | input | DW | Write data |
| ext_last | input | 1 | Marks the final write of a burst |
| ext_claim | output | 1 | Request falls in this channel's window |
| ext_ack | output | 1 | One-cycle completion pulse |
| ext_rdata | output | DW | Read data, valid with ext_ack |
| mem_req | output | 1 | Internal memory word request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory accepts the current word |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| dma_req | output | 1 | Burst pacing request |
| dma_ack | input | 1 | Burst pacing acknowledge |

## Verification
Some behaviours are checked on every cycle by the assertions. Both memory engines must hold their address steady until the word is accepted. `ext_ack` must only follow a claimed request and must never last two cycles. `dma_req` must fall only after an acknowledge. Other behaviours can only be shown by the bench's scenarios, because they depend on counting memory traffic against a model memory. These are prefetch of the following line, discarding both lines on a miss, holding write data until the line fills, ends or changes, draining before an overlapping read, and the data values returned.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESP,
        ST_DRAIN,
        ST_FETCH,
        ST_LOAD
    } bpc_state_e;
endpackage

// File: rtl/bpc_line_fill.sv
module bpc_line_fill #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [AW-$clog2(LINE_BYTES)-1:0] start_line,
    input  logic                          start_sel,
    output logic                          busy,
    output logic                          cur_sel,
    output logic [AW-1:0]                 mem_addr,
    input  logic                          mem_ack,
    output logic                          word_we,
    output logic [$clog2(LINE_BYTES)-$clog2(DW/8)-1:0] word_idx,
    output logic                          done
);
    localparam int WB    = $clog2(DW/8);
    localparam int LB    = $clog2(LINE_BYTES);
    localparam int IW    = LB - WB;
    localparam int LW    = AW - LB;
    localparam int WORDS = LINE_BYTES / (DW/8);

    logic [LW-1:0] line_q;
    logic [IW-1:0] idx_q;
    logic          busy_q;
    logic          sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            line_q <= '0;
            sel_q  <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            line_q <= start_line;
            sel_q  <= start_sel;
        end else if (busy_q && mem_ack) begin
            if (idx_q == IW'(WORDS-1)) busy_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign busy     = busy_q;
    assign cur_sel  = sel_q;
    assign mem_addr = {line_q, idx_q, {WB{1'b0}}};
    assign word_we  = busy_q && mem_ack;
    assign word_idx = idx_q;
    assign done     = word_we && (idx_q == IW'(WORDS-1));

    // R2: a pending line read keeps its address until memory accepts it
    a_r2_fill_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !mem_ack |=> busy_q && $stable(mem_addr));
endmodule

// File: rtl/bpc_write_buf.sv
module bpc_write_buf #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-$clog2(LINE_BYTES)-1:0] wr_line,
    input  logic [$clog2(LINE_BYTES)-$clog2(DW/8)-1:0] wr_idx,
    input  logic [DW-1:0]                 wr_data,
    input  logic                          flush_go,
    output logic                          empty,
    output logic                          full,
    output logic [AW-$clog2(LINE_BYTES)-1:0] line,
    output logic                          mem_req,
    output logic [AW-1:0]                 mem_addr,
    output logic [DW-1:0]                 mem_wdata,
    input  logic                          mem_ack
);
    localparam int WB    = $clog2(DW/8);
    localparam int LB    = $clog2(LINE_BYTES);
    localparam int IW    = LB - WB;
    localparam int LW    = AW - LB;
    localparam int WORDS = LINE_BYTES / (DW/8);

    logic [DW-1:0]    slot [WORDS];
    logic [WORDS-1:0] held_q;
    logic [LW-1:0]    line_q;
    logic [IW-1:0]    ptr_q;

    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
            line_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (wr_en) begin
                held_q[wr_idx] <= 1'b1;
                line_q         <= wr_line;
            end
            if (flush_go) begin
                if (!held_q[ptr_q]) begin
                    ptr_q <= ptr_q + 1'b1;
                end else if (mem_ack) begin
                    held_q[ptr_q] <= 1'b0;
                    ptr_q         <= ptr_q + 1'b1;
                end
            end else begin
                ptr_q <= '0;
            end
        end
    end

    assign empty     = (held_q == '0);
    assign full      = &held_q;
    assign line      = line_q;
    assign mem_req   = flush_go && held_q[ptr_q];
    assign mem_addr  = {line_q, ptr_q, {WB{1'b0}}};
    assign mem_wdata = slot[ptr_q];

    // R6: a pending drain write keeps its address until memory accepts it
    a_r6_drain_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
endmodule

// File: rtl/burst_prefetch_chan.sv
module burst_prefetch_chan
    import bpc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    input  logic          ext_req,
    input  logic          ext_we,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] ext_wdata,
    input  logic          ext_last,
    output logic          ext_claim,
    output logic          ext_ack,
    output logic [DW-1:0] ext_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          dma_req,
    input  logic          dma_ack
);
    localparam int WB    = $clog2(DW/8);
    localparam int LB    = $clog2(LINE_BYTES);
    localparam int IW    = LB - WB;
    localparam int LW    = AW - LB;
    localparam int WORDS = LINE_BYTES / (DW/8);

    bpc_state_e st_q, st_nxt;

    // read line pair
    logic [DW-1:0] rline [2][WORDS];
    logic [LW-1:0] rtag [2];
    logic [1:0]    rtv_q, rfull_q;

    logic          ack_q, last_q, dma_q;
    logic [DW-1:0] rdata_q;

    // engine wiring
    logic          fill_start, fill_busy, fill_sel, fill_we, fill_done, fs_sel;
    logic [LW-1:0] fs_line;
    logic [IW-1:0] fill_idx;
    logic [AW-1:0] fill_maddr;
    logic          wr_en, drain_go, wb_empty, wb_full, wb_mreq;
    logic [LW-1:0] wb_line;
    logic [AW-1:0] wb_maddr;
    logic          acc_rd, drop_rd;

    // request decode
    logic          claim, hit0, hit1, hsel, psel, pf_ok;
    logic [LW-1:0] req_line, next_line;
    logic [IW-1:0] req_idx;

    assign claim     = ext_req && (ext_addr >= win_lo) && (ext_addr <= win_hi);
    assign req_line  = ext_addr[AW-1:LB];
    assign req_idx   = ext_addr[LB-1:WB];
    assign next_line = req_line + 1'b1;
    assign hit0      = rfull_q[0] && (rtag[0] == req_line);
    assign hit1      = rfull_q[1] && (rtag[1] == req_line);
    assign hsel      = !hit0;
    assign psel      = ~hsel;
    assign pf_ok     = !fill_busy
                    && !(rtv_q[psel] && rtag[psel] == next_line)
                    && !(!wb_empty && wb_line == next_line)
                    && ({next_line, {LB{1'b0}}} <= win_hi)
                    && (next_line != '0);

    bpc_line_fill #(.AW(AW), .DW(DW), .LINE_BYTES(LINE_BYTES)) i_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fill_start),
        .start_line (fs_line),
        .start_sel  (fs_sel),
        .busy       (fill_busy),
        .cur_sel    (fill_sel),
        .mem_addr   (fill_maddr),
        .mem_ack    (mem_ack && fill_busy),
        .word_we    (fill_we),
        .word_idx   (fill_idx),
        .done       (fill_done)
    );

    bpc_write_buf #(.AW(AW), .DW(DW), .LINE_BYTES(LINE_BYTES)) i_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_line    (req_line),
        .wr_idx     (req_idx),
        .wr_data    (ext_wdata),
        .flush_go   (drain_go),
        .empty      (wb_empty),
        .full       (wb_full),
        .line       (wb_line),
        .mem_req    (wb_mreq),
        .mem_addr   (wb_maddr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack && !fill_busy)
    );

    assign mem_req  = fill_busy || wb_mreq;
    assign mem_we   = !fill_busy;
    assign mem_addr = fill_busy ? fill_maddr : wb_maddr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // next state and control outputs
    always_comb begin
        st_nxt     = st_q;
        fill_start = 1'b0;
        fs_sel     = 1'b0;
        fs_line    = req_line;
        wr_en      = 1'b0;
        drain_go   = 1'b0;
        acc_rd     = 1'b0;
        drop_rd    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (claim) begin
                    if (ext_we) begin
                        if (!wb_empty && wb_line != req_line) begin
                            st_nxt = ST_DRAIN;
                        end else if (!(fill_busy && i_fill.mem_addr[AW-1:LB] == req_line)) begin
                            wr_en  = 1'b1;
                            st_nxt = ST_RESP;
                        end
                    end else if (!wb_empty && wb_line == req_line) begin
                        st_nxt = ST_DRAIN;
                    end else if (hit0 || hit1) begin
                        acc_rd = 1'b1;
                        st_nxt = ST_RESP;
                        if (pf_ok) begin
                            fill_start = 1'b1;
                            fs_sel     = psel;
                            fs_line    = next_line;
                        end
                    end else begin
                        st_nxt = ST_FETCH;
                    end
                end
            end
            ST_RESP: begin
                st_nxt = (wb_full || (last_q && !wb_empty)) ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: begin
                drain_go = !fill_busy;
                if (wb_empty) st_nxt = ST_IDLE;
            end
            ST_FETCH: begin
                if (!fill_busy) begin
                    drop_rd    = 1'b1;
                    fill_start = 1'b1;
                    st_nxt     = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (fill_done) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (fill_we) rline[fill_sel][fill_idx] <= mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            last_q  <= 1'b0;
            rdata_q <= '0;
            rtv_q   <= '0;
            rfull_q <= '0;
            rtag[0] <= '0;
            rtag[1] <= '0;
            dma_q   <= 1'b0;
        end else begin
            ack_q <= acc_rd || wr_en;
            dma_q <= (|rfull_q) || wb_empty || (dma_q && !dma_ack);
            if (acc_rd) begin
                rdata_q <= rline[hsel][req_idx];
                last_q  <= 1'b0;
            end
            if (wr_en) last_q <= ext_last;
            if (drop_rd) begin
                rtv_q   <= '0;
                rfull_q <= '0;
            end
            if (wr_en) begin
                for (int i = 0; i < 2; i++) begin
                    if (rtv_q[i] && rtag[i] == req_line) begin
                        rtv_q[i]   <= 1'b0;
                        rfull_q[i] <= 1'b0;
                    end
                end
            end
            if (fill_done) rfull_q[fill_sel] <= 1'b1;
            if (fill_start) begin
                rtag[fs_sel]    <= fs_line;
                rtv_q[fs_sel]   <= 1'b1;
                rfull_q[fs_sel] <= 1'b0;
            end
        end
    end

    assign ext_claim = claim;
    assign ext_ack   = ack_q;
    assign ext_rdata = rdata_q;
    assign dma_req   = dma_q;

    // R1: every acknowledge answers a claimed request
    a_r1_ack_only_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack |-> $past(ext_claim));
    // R11: acknowledge never lasts two cycles
    a_r11_ack_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack |=> !ext_ack);
    // R10: the pacing request only falls after an acknowledge
    a_r10_dma_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> $past(dma_ack));
endmodule

// File: tb/test_burst_prefetch_chan.sv
module test_burst_prefetch_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] win_lo = 32'h100;
    logic [31:0] win_hi = 32'h2FF;
    logic        ext_req = 1'b0, ext_we = 1'b0, ext_last = 1'b0;
    logic [31:0] ext_addr = '0, ext_wdata = '0;
    logic        ext_claim, ext_ack;
    logic [31:0] ext_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        dma_req;
    logic        dma_ack = 1'b0;

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    bit finished = 0;
    logic [31:0] model [256];

    always #5 clk = ~clk;

    burst_prefetch_chan i_burst_prefetch_chan (
        .clk(clk), .rst_n(rst_n), .win_lo(win_lo), .win_hi(win_hi),
        .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_last(ext_last), .ext_claim(ext_claim),
        .ext_ack(ext_ack), .ext_rdata(ext_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dma_req(dma_req),
        .dma_ack(dma_ack)
    );

    // model memory: answers one word every other cycle, counts traffic
    initial begin
        for (int i = 0; i < 256; i++) model[i] = 32'h5A00_0000 | (i << 2);
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (mem_we) begin
                    model[mem_addr[9:2]] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = model[mem_addr[9:2]];
                    rd_cnt++;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] d);
        bit got = 0;
        @(negedge clk);
        ext_req = 1'b1; ext_we = 1'b0; ext_addr = a; ext_last = 1'b0;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            if (ext_ack) begin got = 1; break; end
        end
        d = ext_rdata;
        ext_req = 1'b0;
        if (!got) chk(0, "R11 read handshake timeout", 32'(got), 32'd1);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] v, input bit last);
        bit got = 0;
        @(negedge clk);
        ext_req = 1'b1; ext_we = 1'b1; ext_addr = a; ext_wdata = v; ext_last = last;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            if (ext_ack) begin got = 1; break; end
        end
        ext_req = 1'b0; ext_last = 1'b0;
        if (!got) chk(0, "R11 write handshake timeout", 32'(got), 32'd1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(ext_ack == 1'b0, "R12 ack in reset", 32'(ext_ack), 32'd0);
        chk(mem_req == 1'b0, "R12 mem_req in reset", 32'(mem_req), 32'd0);
        chk(dma_req == 1'b0, "R12 dma_req in reset", 32'(dma_req), 32'd0);
        rst_n = 1'b1;
        settle(2);
        chk(dma_req == 1'b1, "R10 dma_req with empty write line", 32'(dma_req), 32'd1);
    endtask

    task automatic t_dma;
        int w0 = wr_cnt;
        do_write(32'h1C0, 32'h1111_0001, 1'b0);
        settle(5);
        chk(dma_req == 1'b1, "R10 dma_req held without ack", 32'(dma_req), 32'd1);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        chk(dma_req == 1'b0, "R10 dma_req dropped after ack", 32'(dma_req), 32'd0);
        do_write(32'h1C4, 32'h1111_0002, 1'b1);
        settle(30);
        chk(dma_req == 1'b1, "R10 dma_req back after drain", 32'(dma_req), 32'd1);
        chk(wr_cnt - w0 == 2, "R7 last write drains two words", 32'(wr_cnt - w0), 32'd2);
    endtask

    task automatic t_window;
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        @(negedge clk);
        ext_we = 1'b0;
        ext_addr = 32'h0FC; ext_req = 1'b1; #1;
        chk(ext_claim == 1'b0, "R1 below window", 32'(ext_claim), 32'd0);
        ext_addr = 32'h100; #1;
        chk(ext_claim == 1'b1, "R1 lower bound", 32'(ext_claim), 32'd1);
        ext_addr = 32'h2FC; #1;
        chk(ext_claim == 1'b1, "R1 upper bound", 32'(ext_claim), 32'd1);
        ext_addr = 32'h400; #1;
        chk(ext_claim == 1'b0, "R1 above window", 32'(ext_claim), 32'd0);
        begin
            bit seen = 0;
            for (int n = 0; n < 20; n++) begin
                @(negedge clk);
                if (ext_ack) seen = 1;
            end
            chk(seen == 0, "R1 unclaimed request acked", 32'(seen), 32'd0);
        end
        ext_req = 1'b0;
        chk(rd_cnt == r0 && wr_cnt == w0, "R1 unclaimed memory traffic",
            32'(rd_cnt - r0 + wr_cnt - w0), 32'd0);
    endtask

    task automatic t_miss_and_prefetch;
        logic [31:0] d;
        int r0 = rd_cnt;
        do_read(32'h108, d);
        chk(d == model[32'h108 >> 2], "R2 miss data", d, model[32'h108 >> 2]);
        settle(60);
        chk(rd_cnt - r0 == 16, "R3 miss plus next-line prefetch", 32'(rd_cnt - r0), 32'd16);
        r0 = rd_cnt;
        do_read(32'h10C, d);
        settle(40);
        chk(d == model[32'h10C >> 2], "R3 hit data", d, model[32'h10C >> 2]);
        chk(rd_cnt == r0, "R3 hit with next line loaded", 32'(rd_cnt - r0), 32'd0);
        r0 = rd_cnt;
        do_read(32'h124, d);
        chk(d == model[32'h124 >> 2], "R3 prefetched line data", d, model[32'h124 >> 2]);
        settle(40);
        chk(rd_cnt - r0 == 8, "R3 ping-pong refill", 32'(rd_cnt - r0), 32'd8);
        do_read(32'h144, d);
        chk(d == model[32'h144 >> 2], "R3 alternate line data", d, model[32'h144 >> 2]);
        settle(40);
    endtask

    task automatic t_discard;
        logic [31:0] d;
        int r0 = rd_cnt;
        do_read(32'h200, d);
        chk(d == model[32'h200 >> 2], "R4 far miss data", d, model[32'h200 >> 2]);
        settle(60);
        r0 = rd_cnt;
        do_read(32'h148, d);
        chk(d == model[32'h148 >> 2], "R4 refetch data", d, model[32'h148 >> 2]);
        settle(60);
        chk(rd_cnt - r0 == 16, "R4 discarded line fetched again", 32'(rd_cnt - r0), 32'd16);
        r0 = rd_cnt;
        do_read(32'h2E4, d);
        chk(d == model[32'h2E4 >> 2], "R3 top line data", d, model[32'h2E4 >> 2]);
        settle(60);
        chk(rd_cnt - r0 == 8, "R3 no prefetch above window", 32'(rd_cnt - r0), 32'd8);
    endtask

    task automatic t_collect_last;
        int w0 = wr_cnt;
        do_write(32'h180, 32'hAAAA_0000, 1'b0);
        do_write(32'h184, 32'hAAAA_0001, 1'b0);
        settle(20);
        chk(wr_cnt == w0, "R5 writes held", 32'(wr_cnt - w0), 32'd0);
        do_write(32'h188, 32'hAAAA_0002, 1'b1);
        settle(30);
        chk(wr_cnt - w0 == 3, "R7 last drains held words", 32'(wr_cnt - w0), 32'd3);
        chk(model[32'h184 >> 2] == 32'hAAAA_0001, "R7 drained value", model[32'h184 >> 2], 32'hAAAA_0001);
    endtask

    task automatic t_full;
        int w0 = wr_cnt;
        for (int k = 0; k < 7; k++) do_write(32'h1A0 + 32'(k*4), 32'hBB00_0000 + 32'(k), 1'b0);
        settle(10);
        chk(wr_cnt == w0, "R5 seven words held", 32'(wr_cnt - w0), 32'd0);
        do_write(32'h1BC, 32'hBB00_0007, 1'b0);
        settle(40);
        chk(wr_cnt - w0 == 8, "R6 full line drained", 32'(wr_cnt - w0), 32'd8);
        chk(model[32'h1BC >> 2] == 32'hBB00_0007, "R6 last slot value", model[32'h1BC >> 2], 32'hBB00_0007);
    endtask

    task automatic t_line_change;
        int w0 = wr_cnt;
        do_write(32'h260, 32'hCC00_0000, 1'b0);
        do_write(32'h284, 32'hCC00_0001, 1'b0);
        settle(10);
        chk(wr_cnt - w0 == 1, "R8 old line drained first", 32'(wr_cnt - w0), 32'd1);
        chk(model[32'h260 >> 2] == 32'hCC00_0000, "R8 old line value", model[32'h260 >> 2], 32'hCC00_0000);
        do_write(32'h288, 32'hCC00_0002, 1'b1);
        settle(20);
        chk(wr_cnt - w0 == 3, "R8 new line collected", 32'(wr_cnt - w0), 32'd3);
    endtask

    task automatic t_overlap;
        logic [31:0] d;
        int w0 = wr_cnt;
        do_write(32'h2E8, 32'hDEAD_0123, 1'b0);
        do_read(32'h2E8, d);
        chk(d == 32'hDEAD_0123, "R9 read sees held write", d, 32'hDEAD_0123);
        chk(wr_cnt - w0 == 1, "R9 write drained before read", 32'(wr_cnt - w0), 32'd1);
        settle(40);
    endtask

    task automatic t_ack_pulse;
        logic [31:0] d;
        do_read(32'h1A4, d);
        chk(d == 32'hBB00_0001, "R11 read data with ack", d, 32'hBB00_0001);
        @(negedge clk);
        chk(ext_ack == 1'b0, "R11 ack one cycle", 32'(ext_ack), 32'd0);
        settle(40);
    endtask

    initial begin
        t_reset();
        t_dma();
        t_window();
        t_miss_and_prefetch();
        t_discard();
        t_collect_last();
        t_full();
        t_line_change();
        t_overlap();
        t_ack_pulse();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule